// File: doc/BRIEF.md
# Digital DLL Delay-Code Controller

This block closes the loop of an all-digital delay-locked loop. Each reference period the phase detector delivers a one-bit verdict, either the delayed clock arrives late or it arrives early. The controller turns that stream of verdicts into a 6-bit code for a binary-weighted delay line. It can acquire by binary search, settling the code in six verdicts from the top bit down, and it then tracks by stepping the code one unit per verdict. Without the search it starts tracking directly from mid-scale, which can take around thirty verdicts to reach a far target.

Two conditions get special handling. The first is a loop that pins the code against either end of its range. The controller treats this as stuck, reloads the mid-scale starting code and starts over. The second is a settled loop. Once the verdicts alternate steadily, the controller declares lock. If hold is enabled it then opens the loop, freezing the code and ignoring verdicts to save power. A re-acquire request from a phase-error monitor closes the loop again.

Top module: `dllCodeController`

## Requirements
- R1: While reset is held low and after it is released, `delayCode` is 6'b100000 (32), and `locked`, `loopOpen` and `stuckFlag` are 0.
- R2: With `sarEnable`=1, acquisition takes six verdicts and tests bit 5 first, then bit 4, and so on down to bit 0. A late verdict (`phaseLate`=1) clears the bit under test and an early verdict (`phaseLate`=0) keeps it. Unless the bit under test is bit 0, the next lower bit is then set for the next trial. After the sixth verdict the controller tracks.
- R3: While tracking, a late verdict lowers the code by one and an early verdict raises it by one. The code saturates at 0 and at 63.
- R4: A verdict counts only in a cycle with `decValid`=1. `phaseLate` has no effect in any other cycle.
- R5: While tracking, `locked` rises with the fifth of five consecutive verdicts that each differ from the one before. This is four alternations. A repeated verdict restarts the count.
- R6: If eight consecutive tracking verdicts are taken while the code is 0 or 63, the eighth one is not applied. Instead the code reloads 32, `locked` clears and `stuckFlag` pulses high for one cycle. The controller then restarts the search if `sarEnable`=1, or tracking if `sarEnable`=0.
- R7: If `holdEn`=1 when lock is declared, `loopOpen` rises with it. While `loopOpen`=1 the code stays frozen and verdicts are ignored.
- R8: `reqReacquire`=1 in tracking or hold clears `locked` and `loopOpen` and keeps the code. A verdict in the same cycle is dropped. During the binary search the request is ignored.
- R9: With `sarEnable`=0, the first verdict after reset steps the code from 32 by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| decValid | input | 1 | One-cycle strobe marking a phase verdict |
| phaseLate | input | 1 | Verdict: 1 = output late (shorten), 0 = early (lengthen) |
| sarEnable | input | 1 | Use binary-search acquisition after reset or stuck restart |
| holdEn | input | 1 | Open the loop once lock is declared |
| reqReacquire | input | 1 | Phase-error request to close the loop again |
| delayCode | output | 6 | Delay-line code |
| locked | output | 1 | Lock declared |
| loopOpen | output | 1 | Loop opened, code frozen |
| stuckFlag | output | 1 | One-cycle pulse after a stuck restart |

## Verification
Two events can land in the same cycle: a re-acquire request and a phase verdict. The bench drives both in one cycle while the loop is open, and again during the binary search. In the first case the code must be unchanged and lock and open-loop must drop together. In the second case the verdict must still resolve its bit. A second collision is the stuck restart against a normal step. The bench checks that the eighth verdict at an end of the range reloads mid-scale and does not saturate or step.

// File: rtl/dllCtrlPkg.sv
package dllCtrlPkg;

  typedef enum logic [1:0] {
    ST_INIT,
    ST_SAR,
    ST_TRACK,
    ST_HOLD
  } loopState_t;

  // Strobes from the loop control to the code datapath
  typedef struct packed {
    logic loadInit;   // reload mid-scale code
    logic sarTrial;   // resolve the bit under test
    logic countStep;  // step the code by one
    logic dirDown;    // verdict: shorten the delay
  } dpStrobe_t;

endpackage

// File: rtl/dllCodeDatapath.sv
module dllCodeDatapath
  import dllCtrlPkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpStrobe_t                 strobe,
  input  logic [$clog2(CODE_W)-1:0] bitIdx,
  output logic [CODE_W-1:0]         code,
  output logic                      codeAtEnd
);

  localparam logic [CODE_W-1:0] INIT_CODE = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CODE_W-1:0] MAX_CODE  = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] MIN_CODE  = '0;

  logic [CODE_W-1:0] sarCode;
  logic [CODE_W-1:0] stepCode;
  logic [CODE_W-1:0] nextCode;

  // One trial per bit: resolve the bit under test, arm the bit below it
  for (genvar i = 0; i < CODE_W; i++) begin : g_sarBit
    assign sarCode[i] = (int'(bitIdx) == i)     ? ~strobe.dirDown :
                        (int'(bitIdx) == i + 1) ? 1'b1 :
                                                  code[i];
  end

  always_comb begin
    stepCode = code;
    if (strobe.dirDown) begin
      if (code != MIN_CODE) stepCode = code - 1'b1;
    end else begin
      if (code != MAX_CODE) stepCode = code + 1'b1;
    end
  end

  always_comb begin
    nextCode = code;
    if (strobe.loadInit)       nextCode = INIT_CODE;
    else if (strobe.sarTrial)  nextCode = sarCode;
    else if (strobe.countStep) nextCode = stepCode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) code <= INIT_CODE;
    else       code <= nextCode;
  end

  assign codeAtEnd = (code == MIN_CODE) || (code == MAX_CODE);

  // R6: a reload always lands on mid-scale
  a_r6_init_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadInit |=> code == INIT_CODE);

  // R3: no wrap past the top of the range
  a_r3_sat_top: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.countStep && !strobe.loadInit && !strobe.dirDown && code == MAX_CODE)
      |=> code == MAX_CODE);

  // R3: no wrap past the bottom of the range
  a_r3_sat_bottom: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.countStep && !strobe.loadInit && strobe.dirDown && code == MIN_CODE)
      |=> code == MIN_CODE);

  // R2: a trial never disturbs bits already resolved above it
  a_r2_upper_kept: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sarTrial && !strobe.loadInit)
      |=> (code >> ($past(bitIdx) + 1'b1)) == ($past(code) >> ($past(bitIdx) + 1'b1)));

endmodule

// File: rtl/dllLoopControl.sv
module dllLoopControl
  import dllCtrlPkg::*;
#(
  parameter int CODE_W    = 6,
  parameter int LOCK_ALT  = 4,
  parameter int STUCK_RUN = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      decValid,
  input  logic                      phaseLate,
  input  logic                      sarEnable,
  input  logic                      holdEn,
  input  logic                      reqReacquire,
  input  logic                      codeAtEnd,
  output dpStrobe_t                 strobe,
  output logic [$clog2(CODE_W)-1:0] bitIdx,
  output logic                      locked,
  output logic                      loopOpen,
  output logic                      stuckFlag
);

  localparam int IDX_W = $clog2(CODE_W);
  localparam int ALT_W = $clog2(LOCK_ALT + 1);
  localparam int END_W = $clog2(STUCK_RUN + 1);
  localparam logic [IDX_W-1:0] MSB_IDX  = IDX_W'(CODE_W - 1);
  localparam logic [ALT_W-1:0] ALT_DONE = ALT_W'(LOCK_ALT);
  localparam logic [END_W-1:0] END_LAST = END_W'(STUCK_RUN - 1);

  loopState_t       state;
  logic [ALT_W-1:0] altCnt;
  logic [ALT_W-1:0] altNext;
  logic [END_W-1:0] endCnt;
  logic             prevLate;
  logic             prevValid;

  logic trackUpd;
  logic reacqTake;
  logic stuckHit;
  logic lockNow;
  logic enterHold;

  always_comb begin
    reacqTake = reqReacquire && (state == ST_TRACK || state == ST_HOLD);
    trackUpd  = (state == ST_TRACK) && decValid && !reqReacquire;
    stuckHit  = trackUpd && codeAtEnd && (endCnt == END_LAST);
    if (prevValid && (phaseLate != prevLate))
      altNext = (altCnt == ALT_DONE) ? altCnt : altCnt + 1'b1;
    else
      altNext = '0;
    lockNow   = trackUpd && !stuckHit && (locked || altNext == ALT_DONE);
    enterHold = lockNow && holdEn;
  end

  always_comb begin
    strobe.loadInit  = stuckHit;
    strobe.sarTrial  = (state == ST_SAR) && decValid;
    strobe.countStep = trackUpd && !stuckHit;
    strobe.dirDown   = phaseLate;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_INIT;
      bitIdx    <= MSB_IDX;
      altCnt    <= '0;
      endCnt    <= '0;
      prevLate  <= 1'b0;
      prevValid <= 1'b0;
      locked    <= 1'b0;
      stuckFlag <= 1'b0;
    end else begin
      stuckFlag <= stuckHit;
      case (state)
        ST_INIT: begin
          state  <= sarEnable ? ST_SAR : ST_TRACK;
          bitIdx <= MSB_IDX;
        end
        ST_SAR: begin
          if (decValid) begin
            if (bitIdx == '0) state <= ST_TRACK;
            else              bitIdx <= bitIdx - 1'b1;
          end
        end
        ST_TRACK, ST_HOLD: begin
          if (reacqTake) begin
            state     <= ST_TRACK;
            locked    <= 1'b0;
            altCnt    <= '0;
            endCnt    <= '0;
            prevValid <= 1'b0;
          end else if (stuckHit) begin
            state     <= sarEnable ? ST_SAR : ST_TRACK;
            bitIdx    <= MSB_IDX;
            locked    <= 1'b0;
            altCnt    <= '0;
            endCnt    <= '0;
            prevValid <= 1'b0;
          end else if (trackUpd) begin
            prevLate  <= phaseLate;
            prevValid <= 1'b1;
            altCnt    <= altNext;
            endCnt    <= codeAtEnd ? endCnt + 1'b1 : '0;
            if (lockNow)   locked <= 1'b1;
            if (enterHold) state  <= ST_HOLD;
          end
        end
        default: state <= ST_INIT;
      endcase
    end
  end

  assign loopOpen = (state == ST_HOLD);

  // R7: the loop is only ever open with lock held
  a_r7_open_locked: assert property (@(posedge clk) disable iff (!rstN)
    loopOpen |-> locked);

  // R5: lock only rises on a verdict
  a_r5_lock_on_verdict: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(decValid));

  // R8 / R6: lock only drops on a request or a stuck restart
  a_r8_unlock_cause: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> ($past(reqReacquire) || $past(stuckHit)));

  // R6: the stuck indication is a single-cycle pulse
  a_r6_pulse_once: assert property (@(posedge clk) disable iff (!rstN)
    stuckFlag |=> !stuckFlag);

  // R2: the last trial hands over to tracking
  a_r2_sar_exit: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SAR && decValid && bitIdx == '0) |=> state == ST_TRACK);

endmodule

// File: rtl/dllCodeController.sv
module dllCodeController
  import dllCtrlPkg::*;
#(
  parameter int CODE_W    = 6,
  parameter int LOCK_ALT  = 4,
  parameter int STUCK_RUN = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              decValid,
  input  logic              phaseLate,
  input  logic              sarEnable,
  input  logic              holdEn,
  input  logic              reqReacquire,
  output logic [CODE_W-1:0] delayCode,
  output logic              locked,
  output logic              loopOpen,
  output logic              stuckFlag
);

  localparam int IDX_W = $clog2(CODE_W);
  localparam logic [CODE_W-1:0] INIT_CODE = CODE_W'(1) << (CODE_W - 1);

  dpStrobe_t        strobe;
  logic [IDX_W-1:0] bitIdx;
  logic             codeAtEnd;

  dllLoopControl #(
    .CODE_W   (CODE_W),
    .LOCK_ALT (LOCK_ALT),
    .STUCK_RUN(STUCK_RUN)
  ) i_control (
    .clk         (clk),
    .rstN        (rstN),
    .decValid    (decValid),
    .phaseLate   (phaseLate),
    .sarEnable   (sarEnable),
    .holdEn      (holdEn),
    .reqReacquire(reqReacquire),
    .codeAtEnd   (codeAtEnd),
    .strobe      (strobe),
    .bitIdx      (bitIdx),
    .locked      (locked),
    .loopOpen    (loopOpen),
    .stuckFlag   (stuckFlag)
  );

  dllCodeDatapath #(
    .CODE_W(CODE_W)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .bitIdx   (bitIdx),
    .code     (delayCode),
    .codeAtEnd(codeAtEnd)
  );

  // R7: an open loop holds the code through the next edge
  a_r7_frozen: assert property (@(posedge clk) disable iff (!rstN)
    loopOpen |=> $stable(delayCode));

  // R6: the stuck pulse coincides with the reloaded code
  a_r6_pulse_code: assert property (@(posedge clk) disable iff (!rstN)
    stuckFlag |-> delayCode == INIT_CODE);

endmodule

// File: tb/test_dllCodeController.sv
`timescale 1ns / 1ps
module test_dllCodeController;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       decValid = 1'b0;
  logic       phaseLate = 1'b0;
  logic       sarEnable = 1'b0;
  logic       holdEn = 1'b0;
  logic       reqReacquire = 1'b0;
  logic [5:0] delayCode;
  logic       locked;
  logic       loopOpen;
  logic       stuckFlag;

  int testsRun = 0;
  int testsFailed = 0;

  always #2 clk = ~clk;

  dllCodeController i_dllCodeController (
    .clk         (clk),
    .rstN        (rstN),
    .decValid    (decValid),
    .phaseLate   (phaseLate),
    .sarEnable   (sarEnable),
    .holdEn      (holdEn),
    .reqReacquire(reqReacquire),
    .delayCode   (delayCode),
    .locked      (locked),
    .loopOpen    (loopOpen),
    .stuckFlag   (stuckFlag)
  );

  task automatic chk(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset(input logic useSar, input logic useHold);
    @(negedge clk);
    rstN = 1'b0;
    decValid = 1'b0;
    reqReacquire = 1'b0;
    sarEnable = useSar;
    holdEn = useHold;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic decide(input logic late);
    decValid = 1'b1;
    phaseLate = late;
    @(negedge clk);
    decValid = 1'b0;
  endtask

  task automatic decideReacq(input logic late);
    decValid = 1'b1;
    phaseLate = late;
    reqReacquire = 1'b1;
    @(negedge clk);
    decValid = 1'b0;
    reqReacquire = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk("R1 code in reset", delayCode, 32);
    chk("R1 locked in reset", locked, 0);
    doReset(1'b0, 1'b0);
    chk("R1 code after reset", delayCode, 32);
    chk("R1 loopOpen after reset", loopOpen, 0);
    chk("R1 stuckFlag after reset", stuckFlag, 0);
    decide(1'b0);
    chk("R9 first step from mid-scale", delayCode, 33);
  endtask

  task automatic t_sarMix;
    doReset(1'b1, 1'b0);
    decide(1'b1);
    chk("R2 msb cleared, bit4 armed", delayCode, 16);
    decide(1'b0);
    chk("R2 bit4 kept, bit3 armed", delayCode, 24);
    decide(1'b1);
    decide(1'b0);
    decide(1'b0);
    decide(1'b1);
    chk("R2 six-verdict result", delayCode, 22);
    decide(1'b0);
    chk("R3 tracking after search", delayCode, 23);
  endtask

  task automatic t_validGate;
    doReset(1'b0, 1'b0);
    for (int i = 0; i < 4; i++) begin
      phaseLate = i[0];
      @(negedge clk);
    end
    chk("R4 no verdict, code kept", delayCode, 32);
  endtask

  task automatic t_lockTrack;
    doReset(1'b0, 1'b0);
    decide(1'b0);
    decide(1'b1);
    decide(1'b0);
    decide(1'b1);
    chk("R5 no lock after three alternations", locked, 0);
    decide(1'b0);
    chk("R5 lock after four alternations", locked, 1);
    chk("R5 code at lock", delayCode, 33);
    chk("R7 loop stays closed without hold", loopOpen, 0);
    decide(1'b0);
    chk("R3 locked tracking still steps", delayCode, 34);
    decideReacq(1'b0);
    chk("R8 reacquire in tracking clears lock", locked, 0);
    chk("R8 verdict dropped with request", delayCode, 34);
  endtask

  task automatic t_noLockRepeat;
    doReset(1'b0, 1'b0);
    decide(1'b0);
    decide(1'b1);
    decide(1'b0);
    decide(1'b1);
    decide(1'b1);
    chk("R5 repeated verdict blocks lock", locked, 0);
  endtask

  task automatic t_holdReacq;
    doReset(1'b0, 1'b1);
    decide(1'b0);
    decide(1'b1);
    decide(1'b0);
    decide(1'b1);
    decide(1'b0);
    chk("R7 loop opens at lock", loopOpen, 1);
    decide(1'b1);
    decide(1'b1);
    chk("R7 verdicts ignored while open", delayCode, 33);
    decideReacq(1'b1);
    chk("R8 loop closes on request", loopOpen, 0);
    chk("R8 lock cleared on request", locked, 0);
    chk("R8 code kept on request", delayCode, 33);
    decide(1'b1);
    chk("R8 tracking resumes", delayCode, 32);
  endtask

  task automatic t_reacqSar;
    doReset(1'b1, 1'b0);
    decideReacq(1'b0);
    chk("R8 request ignored in search", delayCode, 48);
    decide(1'b1);
    chk("R8 search continues", delayCode, 40);
  endtask

  task automatic t_stuckLow;
    doReset(1'b1, 1'b0);
    for (int i = 0; i < 6; i++) decide(1'b1);
    chk("R2 all-late search ends at 0", delayCode, 0);
    for (int i = 0; i < 7; i++) decide(1'b1);
    chk("R3 saturate at 0", delayCode, 0);
    chk("R6 no stuck before eighth", stuckFlag, 0);
    decide(1'b1);
    chk("R6 stuck reload low", delayCode, 32);
    chk("R6 stuck pulse", stuckFlag, 1);
    @(negedge clk);
    chk("R6 pulse one cycle", stuckFlag, 0);
    decide(1'b0);
    chk("R6 search restarts", delayCode, 48);
  endtask

  task automatic t_stuckHigh;
    doReset(1'b0, 1'b0);
    for (int i = 0; i < 31; i++) decide(1'b0);
    chk("R3 reach top", delayCode, 63);
    decide(1'b0);
    chk("R3 saturate at 63", delayCode, 63);
    for (int i = 0; i < 6; i++) decide(1'b0);
    chk("R6 no stuck before eighth high", stuckFlag, 0);
    decide(1'b0);
    chk("R6 stuck reload high", delayCode, 32);
    chk("R6 stuck pulse high", stuckFlag, 1);
    decide(1'b0);
    chk("R6 tracking restarts", delayCode, 33);
  endtask

  initial begin
    #(200000 * 4);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    t_reset();
    t_sarMix();
    t_validGate();
    t_lockTrack();
    t_noLockRepeat();
    t_holdReacq();
    t_reacqSar();
    t_stuckLow();
    t_stuckHigh();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule